// File: doc/BRIEF.md
# Region-Configured Multiplicity Trigger

This block watches 64 digital discriminator hit bits, one per detector pad, while the analog sample memory is being written, and decides when an event is interesting enough to stop writing. Every pad has a 2-bit mode code. The code decides whether the pad's hits count towards the multiplicity. It also decides whether the pad is read out always, only when hit, or never. Each hit is kept alive for a selectable number of sample ticks, so hits that arrive close together in time add up. The registered multiplicity is compared with a 7-bit threshold.

When the count reaches the threshold, the block emits a single-cycle trigger pulse. On the same edge it latches a per-pad read mask that the readout stage uses to choose which channels to digitize. The block then stays quiet until a clear input rearms it. The same clear also forgets which pads have been hit.

Top module: `region_mult_trigger`

## Requirements
- R1: While reset is asserted and right after it is released, `trigPulse` is 0, `multCount` is 0 and `readMask` is all zeros. The block comes out of reset armed.
- R2: Pad i's mode is `padCfg[2i+1:2i]`. Only mode 2'b10 is trigger-enabled. `multCount` equals the number of trigger-enabled pads whose hit is currently held. The count appears in `multCount` two clock edges after the qualifying sample edge.
- R3: Pads in mode 2'b00 (not connected), 2'b01 (if-hit, not triggering) and 2'b11 (always read, not triggering) never add to `multCount`.
- R4: `holdSel` = k gives a hold of k*128 ticks. A hit stays held during the k*128 sample ticks that follow its last hit tick. It is therefore counted on 1 + k*128 consecutive ticks.
- R5: Hits are sampled and hold windows advance only on clock edges where `sampleTick` and `writeActive` are both 1. A hit presented without `sampleTick` has no effect.
- R6: While `writeActive` is 0, all held hits are dropped and incoming hits are ignored. `multCount` therefore reads 0 from the second edge onwards.
- R7: While armed and `writeActive` is 1, `multCount` >= `threshold` makes `trigPulse` go high on the next edge for exactly one cycle.
- R8: After a trigger pulse, no further pulse occurs until `clearTrig` has been seen. On an edge where `clearTrig` is 1, the block rearms and does not fire.
- R9: On the trigger edge, `readMask` loads a set bit for every mode 2'b11 pad. It also sets the bit of every mode 2'b01 or 2'b10 pad that has been hit since the last clear. Mode 2'b00 pads are never set. `readMask` holds its value until the next trigger.
- R10: `clearTrig` erases the hit history, so the next read mask reflects only hits after the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| writeActive | input | 1 | High during the sample-writing phase |
| sampleTick | input | 1 | One-cycle strobe per sample pointer step |
| hitIn | input | 64 | Discriminator hit bits, one per pad |
| padCfg | input | 128 | 2-bit mode code per pad |
| holdSel | input | 2 | Hold window select: 0, 128, 256 or 384 ticks |
| threshold | input | 7 | Multiplicity threshold |
| clearTrig | input | 1 | Rearm trigger and clear hit history |
| trigPulse | output | 1 | Single-cycle trigger pulse |
| multCount | output | 7 | Registered multiplicity of enabled pads |
| readMask | output | 64 | Pads to read, latched on trigger |

## Verification
The checker assumes that `padCfg` does not change while a run is in progress. It derives the bound on `multCount` and the set of unread pads from the current codes, and a mid-run change would make those derived values stale. The rearm check assumes that `clearTrig` is a clean synchronous strobe. The bench programs one fixed mode pattern (pad i gets code i mod 4) before reset and never changes it. It drives every input at the falling edge, holds `clearTrig` for exactly one cycle, and never applies `clearTrig` together with a hit.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

  typedef enum logic [1:0] {
    PAD_OFF          = 2'b00,
    PAD_QUIET_IFHIT  = 2'b01,
    PAD_TRIG_IFHIT   = 2'b10,
    PAD_QUIET_ALWAYS = 2'b11
  } padMode_e;

  typedef struct packed {
    logic sampleEn;
    logic flush;
    logic clearSticky;
    logic latchMask;
  } ctrlStrobe_t;

endpackage

// File: rtl/rmt_datapath.sv
module rmt_datapath
  import rmt_pkg::*;
#(
  parameter int NUM_PADS  = 64,
  parameter int HOLD_STEP = 128,
  parameter int THR_W     = 7,
  parameter int CNT_W     = $clog2(NUM_PADS + 1),
  parameter int HOLD_W    = $clog2(3 * HOLD_STEP + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrlStrobe_t           strobe,
  input  logic [NUM_PADS-1:0]   hitIn,
  input  logic [2*NUM_PADS-1:0] padCfg,
  input  logic [1:0]            holdSel,
  input  logic [THR_W-1:0]      threshold,
  output logic [CNT_W-1:0]      multCount,
  output logic                  countGeThr,
  output logic [NUM_PADS-1:0]   readMask
);

  logic [NUM_PADS-1:0] trigEn;
  logic [NUM_PADS-1:0] readAlways;
  logic [NUM_PADS-1:0] readIfHit;
  logic [NUM_PADS-1:0] heldHit;
  logic [NUM_PADS-1:0] stickyHit;
  logic [HOLD_W-1:0]   holdLen;
  logic [CNT_W-1:0]    countNext;

  assign holdLen = HOLD_W'(32'(holdSel) * HOLD_STEP);

  for (genvar i = 0; i < NUM_PADS; i++) begin : gPad
    padMode_e          mode;
    logic              held;
    logic              sticky;
    logic [HOLD_W-1:0] holdCnt;

    assign mode          = padMode_e'(padCfg[2*i +: 2]);
    assign trigEn[i]     = (mode == PAD_TRIG_IFHIT);
    assign readAlways[i] = (mode == PAD_QUIET_ALWAYS);
    assign readIfHit[i]  = (mode == PAD_QUIET_IFHIT) || (mode == PAD_TRIG_IFHIT);

    always_ff @(posedge clk) begin
      if (!rst_n || strobe.flush) begin
        held    <= 1'b0;
        holdCnt <= '0;
      end else if (strobe.sampleEn) begin
        if (hitIn[i]) begin
          held    <= 1'b1;
          holdCnt <= holdLen;
        end else if (holdCnt != '0) begin
          holdCnt <= holdCnt - 1'b1;
        end else begin
          held <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || strobe.clearSticky) sticky <= 1'b0;
      else if (strobe.sampleEn && hitIn[i]) sticky <= 1'b1;
    end

    assign heldHit[i]   = held;
    assign stickyHit[i] = sticky;
  end

  always_comb begin
    countNext = '0;
    for (int j = 0; j < NUM_PADS; j++) begin
      countNext = countNext + CNT_W'(heldHit[j] & trigEn[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) multCount <= '0;
    else        multCount <= countNext;
  end

  assign countGeThr = (32'(multCount) >= 32'(threshold));

  always_ff @(posedge clk) begin
    if (!rst_n)               readMask <= '0;
    else if (strobe.latchMask) readMask <= readAlways | (readIfHit & stickyHit);
  end

endmodule

// File: rtl/rmt_control.sv
module rmt_control
  import rmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        writeActive,
  input  logic        sampleTick,
  input  logic        clearTrig,
  input  logic        countGeThr,
  output ctrlStrobe_t strobe,
  output logic        trigPulse
);

  logic armed;
  logic fire;

  assign fire = armed && writeActive && countGeThr && !clearTrig;

  always_comb begin
    strobe.sampleEn    = writeActive && sampleTick;
    strobe.flush       = !writeActive;
    strobe.clearSticky = clearTrig;
    strobe.latchMask   = fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b1;
      trigPulse <= 1'b0;
    end else begin
      trigPulse <= fire;
      if (clearTrig) armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end

endmodule

// File: rtl/region_mult_trigger.sv
module region_mult_trigger
  import rmt_pkg::*;
#(
  parameter int NUM_PADS  = 64,
  parameter int HOLD_STEP = 128,
  parameter int THR_W     = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             writeActive,
  input  logic                             sampleTick,
  input  logic [NUM_PADS-1:0]              hitIn,
  input  logic [2*NUM_PADS-1:0]            padCfg,
  input  logic [1:0]                       holdSel,
  input  logic [THR_W-1:0]                 threshold,
  input  logic                             clearTrig,
  output logic                             trigPulse,
  output logic [$clog2(NUM_PADS+1)-1:0]    multCount,
  output logic [NUM_PADS-1:0]              readMask
);

  localparam int CNT_W  = $clog2(NUM_PADS + 1);
  localparam int HOLD_W = $clog2(3 * HOLD_STEP + 1);

  ctrlStrobe_t strobe;
  logic        countGeThr;

  rmt_control uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .writeActive(writeActive),
    .sampleTick (sampleTick),
    .clearTrig  (clearTrig),
    .countGeThr (countGeThr),
    .strobe     (strobe),
    .trigPulse  (trigPulse)
  );

  rmt_datapath #(
    .NUM_PADS (NUM_PADS),
    .HOLD_STEP(HOLD_STEP),
    .THR_W    (THR_W),
    .CNT_W    (CNT_W),
    .HOLD_W   (HOLD_W)
  ) uData (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .hitIn     (hitIn),
    .padCfg    (padCfg),
    .holdSel   (holdSel),
    .threshold (threshold),
    .multCount (multCount),
    .countGeThr(countGeThr),
    .readMask  (readMask)
  );

endmodule

// File: rtl/rmt_checker.sv
module rmt_checker #(
  parameter int NUM_PADS = 64,
  parameter int CNT_W    = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  writeActive,
  input logic                  clearTrig,
  input logic [2*NUM_PADS-1:0] padCfg,
  input logic                  trigPulse,
  input logic [CNT_W-1:0]      multCount,
  input logic [NUM_PADS-1:0]   readMask
);

  logic [NUM_PADS-1:0] ncMask;
  logic [CNT_W:0]      enCount;
  logic                firedSinceClear;

  always_comb begin
    enCount = '0;
    for (int i = 0; i < NUM_PADS; i++) begin
      ncMask[i] = (padCfg[2*i +: 2] == 2'b00);
      enCount   = enCount + (CNT_W+1)'(padCfg[2*i +: 2] == 2'b10);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clearTrig) firedSinceClear <= 1'b0;
    else if (trigPulse)      firedSinceClear <= 1'b1;
  end

  // R1: the first cycle after reset shows an idle block
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!trigPulse && multCount == '0 && readMask == '0));

  // R3: only trigger-enabled pads can contribute
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W+1)'(multCount) <= enCount);

  // R6: two cycles outside the write phase empty the count
  assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!writeActive ##1 !writeActive) |=> (multCount == '0));

  // R7: the trigger is a single-cycle pulse
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |=> !trigPulse);

  // R8: no second pulse without an intervening clear
  assert_no_refire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(trigPulse && firedSinceClear));

  // R9: the mask only changes together with a trigger pulse
  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trigPulse |-> $stable(readMask));

  // R9: unconnected pads are never selected for reading
  assert_nc_unread_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |-> ((readMask & ncMask) == '0));

endmodule

bind region_mult_trigger rmt_checker #(
  .NUM_PADS(NUM_PADS),
  .CNT_W   (CNT_W)
) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .writeActive(writeActive),
  .clearTrig  (clearTrig),
  .padCfg     (padCfg),
  .trigPulse  (trigPulse),
  .multCount  (multCount),
  .readMask   (readMask)
);

// File: tb/sim_region_mult_trigger.sv
module sim_region_mult_trigger;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          writeActive;
  logic          sampleTick;
  logic [NP-1:0] hitIn;
  logic [2*NP-1:0] padCfg;
  logic [1:0]    holdSel;
  logic [6:0]    threshold;
  logic          clearTrig;
  logic          trigPulse;
  logic [6:0]    multCount;
  logic [NP-1:0] readMask;

  logic [NP-1:0] enMask, alwaysMask;
  int vectors = 0;
  int misses  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_mult_trigger u0 (
    .clk(clk), .rst_n(rst_n), .writeActive(writeActive), .sampleTick(sampleTick),
    .hitIn(hitIn), .padCfg(padCfg), .holdSel(holdSel), .threshold(threshold),
    .clearTrig(clearTrig), .trigPulse(trigPulse), .multCount(multCount),
    .readMask(readMask)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NP-1:0] pads(input int a, input int b, input int c, input int d);
    logic [NP-1:0] m = '0;
    if (a >= 0) m[a] = 1'b1;
    if (b >= 0) m[b] = 1'b1;
    if (c >= 0) m[c] = 1'b1;
    if (d >= 0) m[d] = 1'b1;
    return m;
  endfunction

  task automatic test_reset();
    rst_n = 1'b0;
    step(); step();
    check("R1 pulse in reset", 64'(trigPulse), 64'd0);
    rst_n = 1'b1;
    step();
    check("R1 count", 64'(multCount), 64'd0);
    check("R1 pulse", 64'(trigPulse), 64'd0);
    check("R1 mask", readMask, 64'd0);
  endtask

  task automatic count_one(input string req, input logic [NP-1:0] h);
    hitIn = h; step();
    hitIn = '0; step();
    check(req, 64'(multCount), 64'($countones(h & enMask)));
  endtask

  task automatic test_count();
    holdSel = 2'd0; sampleTick = 1'b1; writeActive = 1'b1;
    count_one("R2 all pads", '1);
    count_one("R2 three enabled", pads(2, 6, 10, -1));
    count_one("R3 disabled and nc", ~enMask);
    count_one("R2 mixed", pads(0, 1, 3, 34));
    step();
  endtask

  task automatic test_hold(input int k);
    int ones = 0;
    holdSel = 2'(k); sampleTick = 1'b1;
    hitIn = pads(2, -1, -1, -1); step();
    hitIn = '0;
    for (int n = 0; n < 420; n++) begin
      step();
      if (multCount == 7'd1) ones++;
    end
    check($sformatf("R4 hold k=%0d", k), 64'(ones), 64'(1 + 128 * k));
  endtask

  task automatic test_tick_gate();
    int ones = 0;
    holdSel = 2'd0;
    sampleTick = 1'b1; hitIn = pads(6, -1, -1, -1); step();
    hitIn = '0;
    for (int n = 0; n < 10; n++) begin
      sampleTick = n[0];
      step();
      if (multCount == 7'd1) ones++;
    end
    check("R5 hold counts ticks only", 64'(ones), 64'd2);
    sampleTick = 1'b0; hitIn = pads(2, 6, -1, -1);
    step(); step();
    check("R5 hit without tick", 64'(multCount), 64'd0);
    hitIn = '0; step();
    check("R5 hit without tick later", 64'(multCount), 64'd0);
    sampleTick = 1'b1;
  endtask

  task automatic test_flush();
    holdSel = 2'd3; sampleTick = 1'b1;
    hitIn = pads(2, 6, -1, -1); step();
    hitIn = '0; step();
    check("R4 held before flush", 64'(multCount), 64'd2);
    writeActive = 1'b0; step(); step();
    check("R6 flushed", 64'(multCount), 64'd0);
    hitIn = pads(2, 6, 10, -1); step(); step();
    check("R6 hits ignored", 64'(multCount), 64'd0);
    hitIn = '0; writeActive = 1'b1; holdSel = 2'd0;
    step(); step();
  endtask

  task automatic test_trigger();
    logic [NP-1:0] mask1;
    logic [NP-1:0] mask2;
    threshold = 7'd3; holdSel = 2'd0; sampleTick = 1'b1;
    clearTrig = 1'b1; step(); clearTrig = 1'b0;
    hitIn = pads(0, 1, 2, 6); step();
    hitIn = '0; step(); step();
    check("R7 below threshold", 64'(trigPulse), 64'd0);
    hitIn = pads(2, 6, 10, -1); step();
    hitIn = '0; step();
    check("R7 not yet", 64'(trigPulse), 64'd0);
    step();
    check("R7 pulse", 64'(trigPulse), 64'd1);
    mask1 = alwaysMask | pads(1, 2, 6, 10);
    check("R9 mask at trigger", readMask, mask1);
    step();
    check("R7 one cycle", 64'(trigPulse), 64'd0);
    hitIn = pads(2, 6, 10, 14); step();
    hitIn = '0;
    for (int n = 0; n < 4; n++) begin
      step();
      check("R8 no refire", 64'(trigPulse), 64'd0);
    end
    check("R9 mask held", readMask, mask1);
    clearTrig = 1'b1; step(); clearTrig = 1'b0;
    check("R8 clear does not fire", 64'(trigPulse), 64'd0);
    hitIn = pads(2, 6, 18, -1); step();
    hitIn = '0; step();
    check("R8 rearmed not yet", 64'(trigPulse), 64'd0);
    step();
    check("R8 rearmed pulse", 64'(trigPulse), 64'd1);
    mask2 = alwaysMask | pads(2, 6, 18, -1);
    check("R10 history cleared", readMask, mask2);
    step();
    check("R7 second pulse one cycle", 64'(trigPulse), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      padCfg[2*i +: 2] = 2'(i % 4);
      enMask[i]        = (i % 4 == 2);
      alwaysMask[i]    = (i % 4 == 3);
    end
    rst_n = 1'b0; writeActive = 1'b0; sampleTick = 1'b0; hitIn = '0;
    holdSel = 2'd0; threshold = 7'd127; clearTrig = 1'b0;
    @(negedge clk);
    test_reset();
    test_count();
    test_hold(0);
    test_hold(1);
    test_hold(3);
    test_tick_gate();
    test_flush();
    test_trigger();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule